// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block prepares the second operand of a 32-bit data-processing datapath together with the shifter carry that a flag-setting operation needs. It has no clock and no state. The output settles from the inputs in the same cycle, and the block sits between the register read ports and the ALU.

The operand comes from one of two sources. The first is a register value shifted left or right, either by a 5-bit amount carried in the instruction or by the low byte of a second register. The second is an 8-bit constant rotated right by twice a 4-bit rotate field. Most of the work is in the carry rules:

- An amount of zero passes the incoming carry through.
- Amounts of exactly the data width and above have their own results.
- A zero instruction amount for a right shift stands for a full-width shift.

Some encodings are outside the datapath's scope: rotate by a register amount, and rotate with a zero instruction amount. For these the block passes the value and the carry through untouched and raises an unsupported flag for the decoder.

Top module: `shop_operand_unit`

## Requirements
- R1: `shift_kind` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For any shift amount from 1 to 31, the operand is the shifted value and `carry_out` is the last bit shifted out.
- R2: In instruction-amount form (`use_reg_amount` = 0), an amount of 0 with logical right or arithmetic right acts as a shift by 32.
- R3: In instruction-amount form, logical left by 0 returns the value unchanged, with `carry_out` = `carry_in`.
- R4: In register-amount form (`use_reg_amount` = 1), the amount is the 8-bit `reg_amount`. An amount of 0 returns the value unchanged with `carry_out` = `carry_in`, for every shift kind except rotate.
- R5: Logical left by exactly 32 gives 0 with `carry_out` = value bit 0. Logical left by 33 to 255 gives 0 with `carry_out` = 0.
- R6: Logical right by exactly 32 gives 0 with `carry_out` = value bit 31. Logical right by 33 to 255 gives 0 with `carry_out` = 0.
- R7: Arithmetic right by 32 or more gives every bit equal to value bit 31, with `carry_out` = value bit 31.
- R8: When `use_immediate` = 1, the operand is `imm_byte`, zero-extended and rotated right by 2 × `imm_rot`. `carry_out` is `carry_in` when `imm_rot` = 0 and operand bit 31 otherwise. `unsupported` is 0, and the shift inputs have no effect.
- R9: When `use_immediate` = 0, `unsupported` = 1 for rotate with `use_reg_amount` = 1, or for rotate with `imm_amount` = 0. In that case the operand equals `opnd_val` and `carry_out` = `carry_in`. In every other case `unsupported` = 0.
- R10: Rotate right with an instruction amount from 1 to 31 rotates the value, and `carry_out` equals operand bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | Shift type: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| imm_amount | input | 5 | Shift amount taken from the instruction |
| reg_amount | input | 8 | Low byte of the amount register |
| use_reg_amount | input | 1 | 1 selects the register amount |
| use_immediate | input | 1 | 1 selects the rotated 8-bit constant |
| imm_byte | input | 8 | 8-bit constant |
| imm_rot | input | 4 | Rotate field; the constant rotates by twice this |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Prepared second operand |
| carry_out | output | 1 | Shifter carry-out |
| unsupported | output | 1 | Encoding outside the supported set |

## Verification
The directed tests target the amounts where a plain barrel shifter goes wrong: 0, 1, 31, 32, 33 and 255 in register form, and the zero instruction amount that widens to 32.

Each of these exposes a specific fault:
- A design that reduces the amount modulo 32 returns the unshifted value at 32 and a wrong result at 33.
- A design that drops the widening turns a right shift by 32 into a pass-through.
- A design with an off-by-one carry tap takes the carry from a neighbouring bit of the patterns 0x80000001 and 0x7FFFFFFE.

The immediate-form tests use rotate 0 to check carry pass-through and rotate 15 to check the bit-31 carry. They also check that stale rotate-by-register inputs do not leak an unsupported flag.

// File: rtl/shop_pkg.sv
package shop_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    function automatic int amt_width(input int data_w, input int ramt_w);
        int sh_w;
        sh_w = $clog2(data_w) + 1;
        return (ramt_w + 1 > sh_w) ? ramt_w + 1 : sh_w;
    endfunction

endpackage

// File: rtl/shop_amount_sel.sv
module shop_amount_sel
    import shop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IAMT_W = 5,
    parameter int RAMT_W = 8,
    parameter int AMT_W  = 9
) (
    input  shift_kind_e         kind,
    input  logic [IAMT_W-1:0]   imm_amount,
    input  logic [RAMT_W-1:0]   reg_amount,
    input  logic                use_reg,
    output logic [AMT_W-1:0]    eff_amt,
    output logic                unsup
);

    always_comb begin
        unsup   = 1'b0;
        eff_amt = '0;
        if (use_reg) begin
            eff_amt = AMT_W'(reg_amount);
            unsup   = (kind == SK_ROR);
        end else if ((imm_amount == '0) && ((kind == SK_LSR) || (kind == SK_ASR))) begin
            eff_amt = AMT_W'(DATA_W);
        end else begin
            eff_amt = AMT_W'(imm_amount);
            unsup   = (kind == SK_ROR) && (imm_amount == '0);
        end

        AST_ZERO_WIDENS: assert (use_reg || (imm_amount != '0) || (kind == SK_LSL) ||
                                 (kind == SK_ROR) || (eff_amt == AMT_W'(DATA_W)))
            else $error("zero instruction amount did not widen"); // R2
        AST_REG_ROR_UNSUP: assert (!(use_reg && (kind == SK_ROR)) || unsup)
            else $error("register rotate not flagged"); // R9
    end

endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
    import shop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 9
) (
    input  logic [DATA_W-1:0]   val,
    input  shift_kind_e         kind,
    input  logic [AMT_W-1:0]    amt,
    input  logic                cin,
    output logic [DATA_W-1:0]   res,
    output logic                cout
);

    localparam int SH_W = $clog2(DATA_W) + 1;

    logic                  big;
    logic [SH_W-1:0]       capped;
    logic [DATA_W:0]       wide;
    logic [2*DATA_W-1:0]   dbl;

    always_comb begin
        big    = amt > AMT_W'(DATA_W);
        capped = big ? SH_W'(DATA_W) : amt[SH_W-1:0];
        wide   = '0;
        dbl    = '0;
        res    = val;
        cout   = cin;
        if (amt != '0) begin
            unique case (kind)
                SK_LSL: begin
                    wide = {1'b0, val} << capped;
                    if (big) begin
                        res  = '0;
                        cout = 1'b0;
                    end else begin
                        res  = wide[DATA_W-1:0];
                        cout = wide[DATA_W];
                    end
                end
                SK_LSR: begin
                    wide = {val, 1'b0} >> capped;
                    if (big) begin
                        res  = '0;
                        cout = 1'b0;
                    end else begin
                        res  = wide[DATA_W:1];
                        cout = wide[0];
                    end
                end
                SK_ASR: begin
                    wide = $unsigned($signed({val, 1'b0}) >>> capped);
                    res  = wide[DATA_W:1];
                    cout = wide[0];
                end
                SK_ROR: begin
                    dbl  = {val, val} >> amt[SH_W-2:0];
                    res  = dbl[DATA_W-1:0];
                    cout = res[DATA_W-1];
                end
            endcase
        end

        AST_ZERO_AMT_PASS: assert ((amt != '0) || ((res == val) && (cout == cin)))
            else $error("zero amount altered value or carry"); // R4
        AST_LSL_BEYOND: assert (!((kind == SK_LSL) && big) || ((res == '0) && !cout))
            else $error("left shift beyond width not cleared"); // R5
        AST_LSR_BEYOND: assert (!((kind == SK_LSR) && big) || ((res == '0) && !cout))
            else $error("right shift beyond width not cleared"); // R6
        AST_ASR_SIGN: assert (!((kind == SK_ASR) && (amt >= AMT_W'(DATA_W))) ||
                              ((res == {DATA_W{val[DATA_W-1]}}) && (cout == val[DATA_W-1])))
            else $error("arithmetic shift did not sign fill"); // R7
        AST_ROR_BITS: assert ((kind != SK_ROR) || ($countones(res) == $countones(val)))
            else $error("rotate changed bit count"); // R10
    end

endmodule

// File: rtl/shop_imm_rot.sv
module shop_imm_rot #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]    imm_byte,
    input  logic [ROT_W-1:0]    imm_rot,
    input  logic                cin,
    output logic [DATA_W-1:0]   res,
    output logic                cout
);

    logic [DATA_W-1:0]     zext;
    logic [ROT_W:0]        rot_amt;
    logic [2*DATA_W-1:0]   dbl;

    always_comb begin
        zext    = DATA_W'(imm_byte);
        rot_amt = {imm_rot, 1'b0};
        dbl     = {zext, zext} >> rot_amt;
        res     = dbl[DATA_W-1:0];
        cout    = (imm_rot == '0) ? cin : res[DATA_W-1];

        AST_IMM_BITS: assert ($countones(res) == $countones(imm_byte))
            else $error("constant rotate changed bit count"); // R8
        AST_IMM_ROT0: assert ((imm_rot != '0) || ((res == zext) && (cout == cin)))
            else $error("zero rotate altered constant or carry"); // R8
    end

endmodule

// File: rtl/shop_operand_unit.sv
module shop_operand_unit
    import shop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IAMT_W = 5,
    parameter int RAMT_W = 8,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [DATA_W-1:0]   opnd_val,
    input  logic [1:0]          shift_kind,
    input  logic [IAMT_W-1:0]   imm_amount,
    input  logic [RAMT_W-1:0]   reg_amount,
    input  logic                use_reg_amount,
    input  logic                use_immediate,
    input  logic [IMM_W-1:0]    imm_byte,
    input  logic [ROT_W-1:0]    imm_rot,
    input  logic                carry_in,
    output logic [DATA_W-1:0]   operand_out,
    output logic                carry_out,
    output logic                unsupported
);

    localparam int AMT_W = amt_width(DATA_W, RAMT_W);

    shift_kind_e          kind;
    logic [AMT_W-1:0]     eff_amt;
    logic                 sel_unsup;
    logic [DATA_W-1:0]    sh_res;
    logic                 sh_c;
    logic [DATA_W-1:0]    imm_res;
    logic                 imm_c;

    assign kind = shift_kind_e'(shift_kind);

    shop_amount_sel #(
        .DATA_W (DATA_W),
        .IAMT_W (IAMT_W),
        .RAMT_W (RAMT_W),
        .AMT_W  (AMT_W)
    ) amount_i (
        .kind       (kind),
        .imm_amount (imm_amount),
        .reg_amount (reg_amount),
        .use_reg    (use_reg_amount),
        .eff_amt    (eff_amt),
        .unsup      (sel_unsup)
    );

    shop_barrel #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) barrel_i (
        .val  (opnd_val),
        .kind (kind),
        .amt  (eff_amt),
        .cin  (carry_in),
        .res  (sh_res),
        .cout (sh_c)
    );

    shop_imm_rot #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W)
    ) immrot_i (
        .imm_byte (imm_byte),
        .imm_rot  (imm_rot),
        .cin      (carry_in),
        .res      (imm_res),
        .cout     (imm_c)
    );

    always_comb begin
        if (use_immediate) begin
            operand_out = imm_res;
            carry_out   = imm_c;
            unsupported = 1'b0;
        end else if (sel_unsup) begin
            operand_out = opnd_val;
            carry_out   = carry_in;
            unsupported = 1'b1;
        end else begin
            operand_out = sh_res;
            carry_out   = sh_c;
            unsupported = 1'b0;
        end

        AST_UNSUP_HOLDS: assert (!unsupported || ((operand_out == opnd_val) && (carry_out == carry_in)))
            else $error("unsupported case altered operand"); // R9
        AST_IMM_NEVER_UNSUP: assert (!(use_immediate && unsupported))
            else $error("immediate form flagged unsupported"); // R8
    end

endmodule

// File: tb/shop_operand_unit_tb_top.sv
module shop_operand_unit_tb_top;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] opnd_val       = '0;
    logic [1:0]  shift_kind     = '0;
    logic [4:0]  imm_amount     = '0;
    logic [7:0]  reg_amount     = '0;
    logic        use_reg_amount = 1'b0;
    logic        use_immediate  = 1'b0;
    logic [7:0]  imm_byte       = '0;
    logic [3:0]  imm_rot        = '0;
    logic        carry_in       = 1'b0;
    logic [31:0] operand_out;
    logic        carry_out;
    logic        unsupported;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [31:0] seed = 32'h1357_9BDF;

    shop_operand_unit dut_i (
        .opnd_val       (opnd_val),
        .shift_kind     (shift_kind),
        .imm_amount     (imm_amount),
        .reg_amount     (reg_amount),
        .use_reg_amount (use_reg_amount),
        .use_immediate  (use_immediate),
        .imm_byte       (imm_byte),
        .imm_rot        (imm_rot),
        .carry_in       (carry_in),
        .operand_out    (operand_out),
        .carry_out      (carry_out),
        .unsupported    (unsupported)
    );

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // bit-serial model: returns {carry, value}
    function automatic logic [32:0] model_shift(logic [31:0] v, logic [1:0] k, int n, logic c);
        logic [31:0] x = v;
        logic        cy = c;
        for (int i = 0; i < n; i++) begin
            case (k)
                2'd0: begin cy = x[31]; x = {x[30:0], 1'b0}; end
                2'd1: begin cy = x[0];  x = {1'b0, x[31:1]}; end
                2'd2: begin cy = x[0];  x = {x[31], x[31:1]}; end
                default: begin cy = x[0]; x = {x[0], x[31:1]}; end
            endcase
        end
        return {cy, x};
    endfunction

    task automatic compare(string req, logic [31:0] eo, logic ec, logic eu);
        n_checks++;
        if (operand_out !== eo || carry_out !== ec || unsupported !== eu) begin
            n_fails++;
            $display("FAIL %s: actual op=%h c=%b u=%b expected op=%h c=%b u=%b",
                     req, operand_out, carry_out, unsupported, eo, ec, eu);
        end
    endtask

    task automatic run_shift(string req, logic [31:0] v, logic [1:0] k, bit byreg,
                             logic [7:0] amt, logic cin);
        logic [32:0] r;
        bit          u;
        int          n;
        u = byreg ? (k == 2'd3) : ((k == 2'd3) && (amt[4:0] == 5'd0));
        if (byreg) n = int'(amt);
        else if (amt[4:0] == 5'd0 && (k == 2'd1 || k == 2'd2)) n = 32;
        else n = int'(amt[4:0]);
        r = u ? {cin, v} : model_shift(v, k, n, cin);
        @(negedge clk);
        opnd_val = v; shift_kind = k; use_reg_amount = byreg; use_immediate = 1'b0;
        carry_in = cin;
        if (byreg) begin reg_amount = amt; imm_amount = next_rand() & 5'h1F; end
        else begin imm_amount = amt[4:0]; reg_amount = next_rand() & 8'hFF; end
        imm_byte = next_rand() & 8'hFF; imm_rot = next_rand() & 4'hF;
        #1;
        compare(req, r[31:0], r[32], u);
    endtask

    task automatic run_imm(string req, logic [7:0] b, logic [3:0] rot, logic cin);
        logic [32:0] r;
        r = model_shift({24'd0, b}, 2'd3, 2 * int'(rot), cin);
        if (rot != 4'd0) r[32] = r[31];
        else r[32] = cin;
        @(negedge clk);
        use_immediate = 1'b1; imm_byte = b; imm_rot = rot; carry_in = cin;
        opnd_val = next_rand(); shift_kind = 2'd3; use_reg_amount = 1'b1;
        reg_amount = 8'd7; imm_amount = 5'd0;
        #1;
        compare(req, r[31:0], r[32], 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk); #1;
        compare("R3 idle zero inputs", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_imm_shifts();
        run_shift("R3 lsl imm 0", 32'hDEAD_BEEF, 2'd0, 1'b0, 8'd0, 1'b1);
        run_shift("R3 lsl imm 0 c0", 32'h8000_0001, 2'd0, 1'b0, 8'd0, 1'b0);
        run_shift("R1 lsl imm 1", 32'h8000_0001, 2'd0, 1'b0, 8'd1, 1'b0);
        run_shift("R1 lsl imm 31", 32'h0000_0003, 2'd0, 1'b0, 8'd31, 1'b0);
        run_shift("R1 lsr imm 5", 32'h0000_0010, 2'd1, 1'b0, 8'd5, 1'b0);
        run_shift("R1 asr imm 4", 32'h8000_0008, 2'd2, 1'b0, 8'd4, 1'b0);
        run_shift("R2 lsr imm 0 means 32", 32'h8000_0000, 2'd1, 1'b0, 8'd0, 1'b0);
        run_shift("R2 lsr imm 0 bit31 clear", 32'h7FFF_FFFF, 2'd1, 1'b0, 8'd0, 1'b1);
        run_shift("R2 asr imm 0 neg", 32'h8000_0001, 2'd2, 1'b0, 8'd0, 1'b0);
        run_shift("R2 asr imm 0 pos", 32'h7FFF_FFFE, 2'd2, 1'b0, 8'd0, 1'b1);
    endtask

    task automatic t_reg_bounds();
        logic [7:0]  amts [6] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};
        logic [31:0] vals [2] = '{32'h8000_0001, 32'h7FFF_FFFE};
        for (int k = 0; k < 3; k++)
            for (int a = 0; a < 6; a++)
                for (int v = 0; v < 2; v++)
                    for (int c = 0; c < 2; c++)
                        run_shift(k == 0 ? "R5 reg lsl boundary" :
                                  k == 1 ? "R6 reg lsr boundary" : "R7 reg asr boundary",
                                  vals[v], 2'(k), 1'b1, amts[a], 1'(c));
        run_shift("R4 reg amount 0 lsr", 32'h1234_5678, 2'd1, 1'b1, 8'd0, 1'b1);
        run_shift("R5 lsl 32 bit0", 32'h0000_0001, 2'd0, 1'b1, 8'd32, 1'b0);
        run_shift("R6 lsr 32 bit31", 32'h8000_0000, 2'd1, 1'b1, 8'd32, 1'b0);
        run_shift("R7 asr 200 neg", 32'hF000_0000, 2'd2, 1'b1, 8'd200, 1'b0);
    endtask

    task automatic t_immediate();
        run_imm("R8 rot 0 keeps carry", 8'hA5, 4'd0, 1'b1);
        run_imm("R8 rot 0 carry low", 8'hFF, 4'd0, 1'b0);
        run_imm("R8 rot 1", 8'h03, 4'd1, 1'b0);
        run_imm("R8 rot 4", 8'hF0, 4'd4, 1'b1);
        run_imm("R8 rot 15", 8'h81, 4'd15, 1'b0);
        run_imm("R8 rot 15 zero byte", 8'h00, 4'd15, 1'b1);
    endtask

    task automatic t_unsupported();
        run_shift("R9 ror by reg", 32'hCAFE_F00D, 2'd3, 1'b1, 8'd4, 1'b1);
        run_shift("R9 ror by reg 0", 32'h0F0F_0F0F, 2'd3, 1'b1, 8'd0, 1'b0);
        run_shift("R9 ror imm 0", 32'h1111_2222, 2'd3, 1'b0, 8'd0, 1'b1);
        run_shift("R9 lsl reg not flagged", 32'h1111_2222, 2'd0, 1'b1, 8'd3, 1'b0);
    endtask

    task automatic t_ror_imm();
        run_shift("R10 ror imm 1", 32'h0000_0001, 2'd3, 1'b0, 8'd1, 1'b0);
        run_shift("R10 ror imm 8", 32'h1234_5678, 2'd3, 1'b0, 8'd8, 1'b1);
        run_shift("R10 ror imm 31", 32'h8000_0000, 2'd3, 1'b0, 8'd31, 1'b1);
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r = next_rand();
            run_shift("R1 random shift", next_rand(), r[1:0], r[2], r[15:8], r[3]);
            run_imm("R8 random immediate", r[23:16], r[27:24], r[4]);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_idle();
        t_imm_shifts();
        t_reg_bounds();
        t_immediate();
        t_unsupported();
        t_ror_imm();
        t_random();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule